// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After reset this block walks a list of register-write records held in a serial EEPROM and applies each one to the device's configuration registers. It reads the memory one byte at a time through a simple request/valid port that sits in front of an external EEPROM master. It assembles each record and drives a single-cycle register write with byte enables. A write that sets the full-retrain bit of a port's link control register also sends a one-cycle retrain request to that port.

Loading ends at an end marker, or at the first error. The two errors are a read that never completes and a record that targets a register outside the implemented range. On an error, loading stops at once. The status outputs then record the cause and the EEPROM location, and a halt flag holds the core of the device in reset. Only the SMBus interfaces stay outside that reset. Software clears the halt through the slave SMBus. When loading is disabled by strap, the loader reports done without reading anything and never halts.

Top module: `cfgld_loader`

## Requirements
- R1: When `init_en_i` is low while reset is released, the loader reads no EEPROM byte and issues no register write. It sets done with error code 0, and `core_hold_o` stays low.
- R2: Records start at EEPROM byte 0 and lie back to back, 7 bytes each. Byte 0 is the control byte: bit 7 marks the end, and bits 3:0 are the byte enables. Bytes 1 and 2 are the register word address, low byte first. Bytes 3 to 6 are the 32-bit data, least significant byte first. Each record produces exactly one `reg_wr_en_o` cycle that carries its address, data and enables.
- R3: A control byte with bit 7 set ends loading at once, after exactly 7·N+1 byte reads for N records. Writes come out in EEPROM order, and the loader sets done with error code 0.
- R4: Port p's link control register sits at word address LINK_BASE + p·LINK_STRIDE (0x80, 0x88, 0x90 by default), and its retrain bit is RETRAIN_BIT (bit 5). A write to that register with the bit set and its byte lane enabled drives `retrain_o[p]` high in the same cycle as `reg_wr_en_o`. Otherwise `retrain_o` stays 0.
- R5: A byte request that sees no `ee_rd_valid_i` within TMO_CYC cycles aborts loading with error code 1. The failing byte's EEPROM address is reported. An answer in the TMO_CYC-th cycle is still accepted.
- R6: A record whose address is at or above REG_COUNT is not written. Loading aborts with error code 2, and the reported location is that record's first EEPROM byte.
- R7: Done is set on normal completion and on abort. It stays set until reset, and an error code other than 0 always comes with done.
- R8: `core_hold_o` rises in the cycle after an abort and then holds until `halt_clr_i`. If a clear coincides with the abort, the halt is still set.
- R9: While reset is asserted, done, error, hold, the write strobe, the retrain outputs and the read request are all low.
- R10: After done, no further EEPROM request or register write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_en_i | input | 1 | EEPROM loading enabled (strap) |
| ee_rd_req_o | output | 1 | Byte read request, held until answered |
| ee_rd_addr_o | output | EE_AW | EEPROM byte address |
| ee_rd_valid_i | input | 1 | Read data valid |
| ee_rd_data_i | input | 8 | Read data byte |
| reg_wr_en_o | output | 1 | Register write strobe |
| reg_wr_addr_o | output | REG_AW | Register word address |
| reg_wr_data_o | output | 32 | Register write data |
| reg_wr_be_o | output | 4 | Register write byte enables |
| retrain_o | output | NPORTS | Per-port link retrain pulse |
| sts_done_o | output | 1 | Loading finished or aborted |
| sts_err_o | output | 1 | Loading aborted |
| sts_code_o | output | 2 | 0 none, 1 read timeout, 2 bad record |
| sts_where_o | output | EE_AW | EEPROM address tied to the error |
| halt_clr_i | input | 1 | Software clear of the halt |
| core_hold_o | output | 1 | Hold core logic in reset |

## Verification
An abort and a software clear of the halt can reach the halt register in the same cycle. The bench holds `halt_clr_i` high through a load that ends on a bad record. The halt must be set at the first sample after done rises and released one cycle later. A write and a retrain request are also meant to coincide. The bench logs `retrain_o` only in cycles with `reg_wr_en_o` and counts any stray pulse. That check covers link registers whose retrain bit is set, cleared, or masked out by its byte enable.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_ISSUE,
        ST_WAIT,
        ST_APPLY,
        ST_END
    } ld_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_BADREC  = 2'd2
    } ld_err_e;

    localparam int REC_BYTES = 7;
    localparam int CTL_END_BIT = 7;
endpackage

// File: rtl/cfgld_byte_fetch.sv
module cfgld_byte_fetch #(
    parameter int EE_AW   = 12,
    parameter int TMO_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [EE_AW-1:0] addr_i,
    output logic             rd_req_o,
    output logic [EE_AW-1:0] rd_addr_o,
    input  logic             rd_valid_i,
    input  logic [7:0]       rd_data_i,
    output logic             got_o,
    output logic [7:0]       data_o,
    output logic             tmo_o
);
    localparam int CW = $clog2(TMO_CYC + 1);

    typedef struct packed {
        logic             active;
        logic [EE_AW-1:0] addr;
        logic [CW-1:0]    cnt;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d   = f_q;
        got_o = f_q.active && rd_valid_i;
        tmo_o = f_q.active && !rd_valid_i && (f_q.cnt == CW'(TMO_CYC - 1));
        if (go_i) begin
            f_d.active = 1'b1;
            f_d.addr   = addr_i;
            f_d.cnt    = '0;
        end else if (f_q.active) begin
            if (got_o || tmo_o) begin
                f_d.active = 1'b0;
            end else begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign rd_req_o  = f_q.active;
    assign rd_addr_o = f_q.addr;
    assign data_o    = rd_data_i;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i && !tmo_o) |=> (rd_req_o && $stable(rd_addr_o))); // R2
    AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !rd_req_o); // R2
    AST_TMO_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_o && !go_i) |=> !rd_req_o); // R5
endmodule

// File: rtl/cfgld_rec_decode.sv
module cfgld_rec_decode #(
    parameter int NPORTS      = 3,
    parameter int REG_COUNT   = 640,
    parameter int LINK_BASE   = 'h80,
    parameter int LINK_STRIDE = 8,
    parameter int RETRAIN_BIT = 5
) (
    input  logic [15:0]       addr_i,
    input  logic [31:0]       data_i,
    input  logic [3:0]        be_i,
    output logic              in_range_o,
    output logic [NPORTS-1:0] retrain_hit_o
);
    localparam int RT_LANE = RETRAIN_BIT / 8;

    assign in_range_o = addr_i < 16'(REG_COUNT);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam logic [15:0] LINK_ADDR = 16'(LINK_BASE + p * LINK_STRIDE);
        assign retrain_hit_o[p] = (addr_i == LINK_ADDR) && be_i[RT_LANE] && data_i[RETRAIN_BIT];
    end
endmodule

// File: rtl/cfgld_halt_ctl.sv
module cfgld_halt_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic err_evt_i,
    input  logic clr_i,
    output logic halt_o
);
    logic halt_d, halt_q;

    always_comb begin
        halt_d = halt_q;
        if (err_evt_i) begin
            halt_d = 1'b1;
        end else if (clr_i) begin
            halt_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else begin
            halt_q <= halt_d;
        end
    end

    assign halt_o = halt_q;

    AST_HALT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt_i |=> halt_o); // R8
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !clr_i) |=> halt_o); // R8
    AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !err_evt_i) |=> !halt_o); // R8
endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader #(
    parameter int EE_AW       = 12,
    parameter int TMO_CYC     = 64,
    parameter int NPORTS      = 3,
    parameter int REG_COUNT   = 640,
    parameter int LINK_BASE   = 'h80,
    parameter int LINK_STRIDE = 8,
    parameter int RETRAIN_BIT = 5,
    localparam int REG_AW     = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_en_i,
    output logic              ee_rd_req_o,
    output logic [EE_AW-1:0]  ee_rd_addr_o,
    input  logic              ee_rd_valid_i,
    input  logic [7:0]        ee_rd_data_i,
    output logic              reg_wr_en_o,
    output logic [REG_AW-1:0] reg_wr_addr_o,
    output logic [31:0]       reg_wr_data_o,
    output logic [3:0]        reg_wr_be_o,
    output logic [NPORTS-1:0] retrain_o,
    output logic              sts_done_o,
    output logic              sts_err_o,
    output logic [1:0]        sts_code_o,
    output logic [EE_AW-1:0]  sts_where_o,
    input  logic              halt_clr_i,
    output logic              core_hold_o
);
    import cfgld_pkg::*;

    localparam logic [2:0] LAST_IDX = 3'(REC_BYTES - 1);

    typedef struct packed {
        ld_state_e        st;
        logic [2:0]       idx;
        logic [EE_AW-1:0] ptr;
        logic [EE_AW-1:0] rec_start;
        logic [3:0]       be;
        logic [15:0]      addr;
        logic [31:0]      data;
        logic             done;
        ld_err_e          code;
        logic [EE_AW-1:0] where;
    } ld_t;

    ld_t s_d, s_q;

    logic              go;
    logic              wr_en;
    logic              err_evt;
    logic              f_got;
    logic              f_tmo;
    logic [7:0]        f_byte;
    logic              in_range;
    logic [NPORTS-1:0] rt_hit;

    cfgld_byte_fetch #(
        .EE_AW   (EE_AW),
        .TMO_CYC (TMO_CYC)
    ) fetch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .addr_i     (s_q.ptr),
        .rd_req_o   (ee_rd_req_o),
        .rd_addr_o  (ee_rd_addr_o),
        .rd_valid_i (ee_rd_valid_i),
        .rd_data_i  (ee_rd_data_i),
        .got_o      (f_got),
        .data_o     (f_byte),
        .tmo_o      (f_tmo)
    );

    cfgld_rec_decode #(
        .NPORTS      (NPORTS),
        .REG_COUNT   (REG_COUNT),
        .LINK_BASE   (LINK_BASE),
        .LINK_STRIDE (LINK_STRIDE),
        .RETRAIN_BIT (RETRAIN_BIT)
    ) decode_i (
        .addr_i        (s_q.addr),
        .data_i        (s_q.data),
        .be_i          (s_q.be),
        .in_range_o    (in_range),
        .retrain_hit_o (rt_hit)
    );

    cfgld_halt_ctl halt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_evt_i (err_evt),
        .clr_i     (halt_clr_i),
        .halt_o    (core_hold_o)
    );

    always_comb begin
        s_d     = s_q;
        go      = 1'b0;
        wr_en   = 1'b0;
        err_evt = 1'b0;
        unique case (s_q.st)
            ST_BOOT: begin
                s_d.ptr       = '0;
                s_d.rec_start = '0;
                s_d.idx       = '0;
                if (init_en_i) begin
                    s_d.st = ST_ISSUE;
                end else begin
                    s_d.done = 1'b1;
                    s_d.st   = ST_END;
                end
            end
            ST_ISSUE: begin
                go     = 1'b1;
                s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (f_got) begin
                    s_d.ptr = s_q.ptr + 1'b1;
                    if (s_q.idx == 3'd0) begin
                        s_d.be = f_byte[3:0];
                    end else if (s_q.idx <= 3'd2) begin
                        s_d.addr = {f_byte, s_q.addr[15:8]};
                    end else begin
                        s_d.data = {f_byte, s_q.data[31:8]};
                    end
                    if (s_q.idx == 3'd0 && f_byte[CTL_END_BIT]) begin
                        s_d.done = 1'b1;
                        s_d.st   = ST_END;
                    end else if (s_q.idx == LAST_IDX) begin
                        s_d.idx = '0;
                        s_d.st  = ST_APPLY;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.st  = ST_ISSUE;
                    end
                end else if (f_tmo) begin
                    err_evt   = 1'b1;
                    s_d.done  = 1'b1;
                    s_d.code  = ERR_TIMEOUT;
                    s_d.where = s_q.ptr;
                    s_d.st    = ST_END;
                end
            end
            ST_APPLY: begin
                if (in_range) begin
                    wr_en         = 1'b1;
                    s_d.rec_start = s_q.ptr;
                    s_d.st        = ST_ISSUE;
                end else begin
                    err_evt   = 1'b1;
                    s_d.done  = 1'b1;
                    s_d.code  = ERR_BADREC;
                    s_d.where = s_q.rec_start;
                    s_d.st    = ST_END;
                end
            end
            ST_END: begin
                s_d.st = ST_END;
            end
            default: begin
                s_d.st = ST_END;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_BOOT;
            s_q.code <= ERR_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_wr_en_o   = wr_en;
    assign reg_wr_addr_o = s_q.addr[REG_AW-1:0];
    assign reg_wr_data_o = s_q.data;
    assign reg_wr_be_o   = s_q.be;
    assign retrain_o     = wr_en ? rt_hit : '0;
    assign sts_done_o    = s_q.done;
    assign sts_code_o    = s_q.code;
    assign sts_err_o     = (s_q.code != ERR_NONE);
    assign sts_where_o   = s_q.where;

    AST_RETRAIN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|retrain_o) |-> reg_wr_en_o); // R4
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        sts_done_o |-> (!reg_wr_en_o && !ee_rd_req_o)); // R10
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sts_done_o |=> sts_done_o); // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        sts_err_o |-> sts_done_o); // R7
    AST_HOLD_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        core_hold_o |-> sts_err_o); // R8
    AST_ONE_REQ_OR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en_o && ee_rd_req_o)); // R2
endmodule

// File: tb/cfgld_loader_tb_top.sv
module cfgld_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int EE_AW      = 12;
    localparam int TMO        = 16;
    localparam int NP         = 3;
    localparam int REGS       = 640;
    localparam int LBASE      = 'h80;
    localparam int LSTRIDE    = 8;
    localparam int RBIT       = 5;
    localparam int RAW        = $clog2(REGS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              init_en = 1'b1;
    logic              rd_req;
    logic [EE_AW-1:0]  rd_addr;
    logic              rd_valid = 1'b0;
    logic [7:0]        rd_data = '0;
    logic              wr_en;
    logic [RAW-1:0]    wr_addr;
    logic [31:0]       wr_data;
    logic [3:0]        wr_be;
    logic [NP-1:0]     retrain;
    logic              done;
    logic              err;
    logic [1:0]        code;
    logic [EE_AW-1:0]  where;
    logic              halt_clr = 1'b0;
    logic              hold;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfgld_loader #(
        .EE_AW(EE_AW), .TMO_CYC(TMO), .NPORTS(NP), .REG_COUNT(REGS),
        .LINK_BASE(LBASE), .LINK_STRIDE(LSTRIDE), .RETRAIN_BIT(RBIT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .init_en_i(init_en),
        .ee_rd_req_o(rd_req), .ee_rd_addr_o(rd_addr),
        .ee_rd_valid_i(rd_valid), .ee_rd_data_i(rd_data),
        .reg_wr_en_o(wr_en), .reg_wr_addr_o(wr_addr),
        .reg_wr_data_o(wr_data), .reg_wr_be_o(wr_be),
        .retrain_o(retrain), .sts_done_o(done), .sts_err_o(err),
        .sts_code_o(code), .sts_where_o(where),
        .halt_clr_i(halt_clr), .core_hold_o(hold)
    );

    int checks = 0;
    int fails = 0;

    logic [7:0] mem [256];
    int silent_addr = -1;
    int lat = 0;
    int wcnt = 0;
    int n_rd = 0;
    logic req_prev = 1'b0;

    int          n_wr = 0;
    int          stray = 0;
    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];
    logic [3:0]  log_be   [16];
    logic [NP-1:0] log_rt [16];

    // EEPROM model and write monitor, both on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            wcnt     <= 0;
            req_prev <= 1'b0;
        end else begin
            req_prev <= rd_req;
            if (rd_req && !req_prev) n_rd <= n_rd + 1;
            if (!rd_req) begin
                rd_valid <= 1'b0;
                wcnt     <= 0;
            end else if (!rd_valid && int'(rd_addr) != silent_addr) begin
                if (wcnt >= lat) begin
                    rd_valid <= 1'b1;
                    rd_data  <= mem[rd_addr[7:0]];
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
            if (wr_en && n_wr < 16) begin
                log_addr[n_wr] <= 32'(wr_addr);
                log_data[n_wr] <= wr_data;
                log_be[n_wr]   <= wr_be;
                log_rt[n_wr]   <= retrain;
                n_wr <= n_wr + 1;
            end
            if (!wr_en && retrain != '0) stray <= stray + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start(input logic en);
        rst_n = 1'b0;
        init_en = en;
        halt_clr = 1'b0;
        silent_addr = -1;
        repeat (3) @(posedge clk);
        n_wr = 0;
        n_rd = 0;
        stray = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic put_rec(input int p, input logic [3:0] be, input logic [15:0] a, input logic [31:0] d);
        mem[p]   = {4'h0, be};
        mem[p+1] = a[7:0];
        mem[p+2] = a[15:8];
        for (int k = 0; k < 4; k++) mem[p+3+k] = d[8*k +: 8];
    endtask

    task automatic put_end(input int p);
        mem[p] = 8'h80;
    endtask

    function automatic logic [NP-1:0] exp_rt(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [NP-1:0] r = '0;
        for (int p = 0; p < NP; p++)
            r[p] = (a == 16'(LBASE + p * LSTRIDE)) && be[RBIT / 8] && d[RBIT];
        return r;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        init_en = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk({done, err, hold, wr_en, rd_req, retrain} == '0, "R9 reset outputs",
            longint'({done, err, hold, wr_en, rd_req, retrain}), 0);
    endtask

    task automatic t_disabled();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        start(1'b0);
        wait_done();
        repeat (5) @(negedge clk);
        chk(done && code == 2'd0, "R1 done without load", longint'({done, code}), 4);
        chk(n_rd == 0 && n_wr == 0, "R1 no reads or writes", longint'(n_rd + n_wr), 0);
        chk(!hold, "R1 no halt", longint'(hold), 0);
    endtask

    task automatic t_basic();
        logic [15:0] a [3] = '{16'h0010, 16'h027F, 16'h0001};
        logic [31:0] d [3] = '{32'hDEADBEEF, 32'h01234567, 32'hA5A55A5A};
        logic [3:0]  b [3] = '{4'hF, 4'h3, 4'h8};
        for (int r = 0; r < 3; r++) put_rec(7 * r, b[r], a[r], d[r]);
        put_end(21);
        lat = 2;
        start(1'b1);
        wait_done();
        chk(n_wr == 3, "R2 write count", n_wr, 3);
        for (int r = 0; r < 3; r++) begin
            chk(log_addr[r] == 32'(a[r]), "R3 write order/address", log_addr[r], a[r]);
            chk(log_data[r] == d[r], "R2 write data", log_data[r], d[r]);
            chk(log_be[r] == b[r], "R2 byte enables", log_be[r], b[r]);
        end
        chk(n_rd == 22, "R3 byte reads to end marker", n_rd, 22);
        chk(done && !err && code == 2'd0, "R3 clean completion", code, 0);
        chk(!hold, "R8 no halt on success", hold, 0);
    endtask

    task automatic t_retrain();
        logic [15:0] a [5] = '{16'h0088, 16'h0080, 16'h0090, 16'h0090, 16'h0081};
        logic [31:0] d [5] = '{32'h00000020, 32'h00000020, 32'hFFFFFFDF, 32'h12340021, 32'h00000020};
        logic [3:0]  b [5] = '{4'h1, 4'hE, 4'hF, 4'h1, 4'hF};
        for (int r = 0; r < 5; r++) put_rec(7 * r, b[r], a[r], d[r]);
        put_end(35);
        lat = 0;
        start(1'b1);
        wait_done();
        chk(n_wr == 5, "R4 write count", n_wr, 5);
        for (int r = 0; r < 5; r++)
            chk(log_rt[r] == exp_rt(a[r], d[r], b[r]), "R4 retrain with write",
                log_rt[r], exp_rt(a[r], d[r], b[r]));
        chk(stray == 0, "R4 no retrain outside write", stray, 0);
    endtask

    task automatic t_timeout();
        put_rec(0, 4'hF, 16'h0020, 32'h11112222);
        put_rec(7, 4'hF, 16'h0021, 32'h33334444);
        put_end(14);
        lat = 1;
        start(1'b1);
        silent_addr = 10;
        wait_done();
        chk(code == 2'd1 && err, "R5 timeout code", code, 1);
        chk(where == 12'd10, "R5 timeout location", where, 10);
        chk(n_wr == 1, "R5 only first record written", n_wr, 1);
        @(negedge clk);
        chk(hold, "R8 halt after abort", hold, 1);
        repeat (40) @(negedge clk);
        chk(n_wr == 1 && !rd_req && n_rd == 11, "R10 quiet after abort", n_rd, 11);
        halt_clr = 1'b1;
        @(negedge clk);
        halt_clr = 1'b0;
        chk(!hold, "R8 clear releases halt", hold, 0);
        chk(done && code == 2'd1, "R7 status kept after clear", longint'({done, code}), 5);
    endtask

    task automatic t_tmo_edge();
        put_rec(0, 4'h5, 16'h0042, 32'hCAFEF00D);
        put_end(7);
        lat = TMO - 1;
        start(1'b1);
        wait_done();
        chk(code == 2'd0 && n_wr == 1, "R5 answer in last cycle accepted", code, 0);
        lat = TMO;
        start(1'b1);
        wait_done();
        chk(code == 2'd1 && where == 12'd0, "R5 answer one cycle late", code, 1);
        lat = 0;
    endtask

    task automatic t_badrec();
        put_rec(0, 4'hF, 16'h0003, 32'h00000001);
        put_rec(7, 4'hF, 16'(REGS), 32'h00000002);
        put_end(14);
        start(1'b1);
        wait_done();
        chk(code == 2'd2, "R6 bad record code", code, 2);
        chk(where == 12'd7, "R6 bad record location", where, 7);
        chk(n_wr == 1, "R6 out-of-range not written", n_wr, 1);
        @(negedge clk);
        chk(hold && done, "R7 done on abort", longint'({hold, done}), 3);
    endtask

    task automatic t_clr_race();
        put_rec(0, 4'hF, 16'hFFFF, 32'h0);
        start(1'b1);
        halt_clr = 1'b1;
        wait_done();
        chk(hold, "R8 abort wins over same-cycle clear", hold, 1);
        @(negedge clk);
        chk(!hold, "R8 held clear releases next cycle", hold, 0);
        halt_clr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        t_reset();
        t_disabled();
        t_basic();
        t_retrain();
        t_timeout();
        t_tmo_edge();
        t_badrec();
        t_clr_race();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule